// File: doc/BRIEF.md
# Flash command sequencer

This block sits on the host side of an asynchronous parallel flash. A request names an operation: program one byte, erase a sector, erase the whole array, or read the identification bytes. The block expands that request into the fixed chain of unlock and command writes the flash needs. It drives chip enable, output enable, write enable, an 18-bit address and a tristate-controlled 8-bit data bus. Every bus cycle is shaped from pulse widths given in nanoseconds. These are rounded up to whole system-clock periods when the block elaborates.

After the last bus cycle of a program or erase, the block does not poll the flash. It waits a fixed number of clocks, sized for the worst-case internal operation time, and then raises `done` for one clock. An identification read captures the two code bytes in registers. It then writes the exit command that returns the flash to array reads. Requests are taken only while the block is idle.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is held, and while idle after it, `fl_ce_n`, `fl_oe_n` and `fl_we_n` are high, `fl_dq_oe` is low, and `busy` and `done` are low.
- R2: `req_op`=0 (byte program) issues four writes in this order: AAh to 05555h, 55h to 02AAAh, A0h to 05555h, and then `req_data` to `req_addr`.
- R3: `req_op`=1 (sector erase) issues six writes. The first five are AAh@05555h, 55h@02AAAh, 80h@05555h, AAh@05555h and 55h@02AAAh. The sixth is 30h to `req_addr`, which is the sector address.
- R4: `req_op`=2 (chip erase) issues the same first five writes as R3, then 10h to 05555h.
- R5: `req_op`=3 (identify) issues AAh@05555h, 55h@02AAAh and 90h@05555h. It then reads address 0 into `id_mfr` and address 1 into `id_dev`, and finally writes F0h to address 0.
- R6: Each write cycle holds `fl_ce_n` low and `fl_oe_n` high throughout. `fl_we_n` is high for SU clocks, low for WP clocks, then high for WPH clocks. WP = ceil(TWP_NS/CLK_NS) and WPH = ceil(TWPH_NS/CLK_NS). SU is the least value of at least 1 that makes SU+WP cover the data setup time and SU+WP+WPH cover the write cycle time. At 20 ns with defaults, SU/WP/WPH are 1/3/2.
- R7: Every bus cycle is preceded by one gap clock with `fl_ce_n`, `fl_we_n` and `fl_oe_n` high and `fl_dq_oe` low. Address and data stay constant for the whole cycle.
- R8: `fl_dq_oe` is high during all clocks of a write cycle and never while `fl_oe_n` is low. A read cycle is one clock with `fl_ce_n` low and `fl_oe_n` high, followed by RD = ceil(TACC_NS/CLK_NS) clocks (5 by default) with `fl_oe_n` low. The data is sampled on the last of these clocks.
- R9: After the final bus cycle, `busy` stays high for L+1 more clocks. L is PROG_WAIT, SERASE_WAIT, CERASE_WAIT or 0 for ops 0..3. `done` is then high for exactly one clock, with `busy` already low.
- R10: A request is accepted when `req_valid` is high while `busy` and `done` are low. `busy` rises on the next clock. Requests made while busy are ignored and leave the running sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_op | input | 2 | Operation: 0 program, 1 sector erase, 2 chip erase, 3 identify |
| req_addr | input | 18 | Byte address for program, sector address for sector erase |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | Sequence or timeout in progress |
| done | output | 1 | One-clock pulse when an operation completes |
| id_mfr | output | 8 | Maker code captured by identify |
| id_dev | output | 8 | Device code captured by identify |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | 18 | Flash address |
| fl_dq_out | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | 8 | Data returned by the flash |

## Verification
Each operation code runs with a different address and data pattern. A mix-up in the command table, such as a wrong code byte, a swapped unlock address, or the sector address replaced by the fixed one, then shows on a distinct bus clock. Program runs at the all-ones and zero corners separate user data from command bytes. The identify run returns different bytes at addresses 0 and 1, so a swapped capture is caught. The three erase and program timeouts differ in length, so a wrong per-op wait shows as a `done` pulse on the wrong clock. A request raised in the middle of a program must leave the clock-by-clock bus trace unchanged.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

   typedef enum logic [1:0] {
      OP_PROG = 2'd0,
      OP_SECT = 2'd1,
      OP_CHIP = 2'd2,
      OP_IDRD = 2'd3
   } fcs_op_e;

   typedef enum logic {
      K_WR = 1'b0,
      K_RD = 1'b1
   } fcs_kind_e;

   // command bytes
   localparam logic [7:0] C_UNLK_A = 8'hAA;
   localparam logic [7:0] C_UNLK_B = 8'h55;
   localparam logic [7:0] C_PGM    = 8'hA0;
   localparam logic [7:0] C_ERSU   = 8'h80;
   localparam logic [7:0] C_SECT   = 8'h30;
   localparam logic [7:0] C_CHIP   = 8'h10;
   localparam logic [7:0] C_IDENT  = 8'h90;
   localparam logic [7:0] C_EXIT   = 8'hF0;

   // unlock addresses (low 16 bits)
   localparam logic [15:0] U_ADDR_A = 16'h5555;
   localparam logic [15:0] U_ADDR_B = 16'h2AAA;

   function automatic int fcs_cdiv(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int fcs_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fcs_cmd_table.sv
module fcs_cmd_table
   import fcs_pkg::*;
#(
   parameter int AW = 18,
   parameter int DW = 8
) (
   input  fcs_op_e         op,
   input  logic [2:0]      step,
   input  logic [AW-1:0]   uaddr,
   input  logic [DW-1:0]   udata,
   output fcs_kind_e       kind,
   output logic [AW-1:0]   addr,
   output logic [DW-1:0]   data,
   output logic            last
);

   localparam logic [AW-1:0] ADR_A = AW'(U_ADDR_A);
   localparam logic [AW-1:0] ADR_B = AW'(U_ADDR_B);

   generate
      if (AW < 16) begin : g_aw_chk
         $error("fcs_cmd_table: AW must hold the unlock addresses");
      end
      if (DW != 8) begin : g_dw_chk
         $error("fcs_cmd_table: command bytes need DW of 8");
      end
   endgenerate

   always_comb begin
      kind = K_WR;
      addr = ADR_A;
      data = C_UNLK_A;
      case (step)
         3'd0: begin
            addr = ADR_A;
            data = C_UNLK_A;
         end
         3'd1: begin
            addr = ADR_B;
            data = C_UNLK_B;
         end
         3'd2: begin
            addr = ADR_A;
            case (op)
               OP_PROG: data = C_PGM;
               OP_IDRD: data = C_IDENT;
               default: data = C_ERSU;
            endcase
         end
         3'd3: begin
            case (op)
               OP_PROG: begin
                  addr = uaddr;
                  data = udata;
               end
               OP_IDRD: begin
                  kind = K_RD;
                  addr = '0;
                  data = '0;
               end
               default: begin
                  addr = ADR_A;
                  data = C_UNLK_A;
               end
            endcase
         end
         3'd4: begin
            if (op == OP_IDRD) begin
               kind = K_RD;
               addr = AW'(1);
               data = '0;
            end else begin
               addr = ADR_B;
               data = C_UNLK_B;
            end
         end
         default: begin
            case (op)
               OP_SECT: begin
                  addr = uaddr;
                  data = C_SECT;
               end
               OP_CHIP: begin
                  addr = ADR_A;
                  data = C_CHIP;
               end
               default: begin
                  addr = '0;
                  data = C_EXIT;
               end
            endcase
         end
      endcase
   end

   assign last = (op == OP_PROG) ? (step == 3'd3) : (step == 3'd5);

endmodule

// File: rtl/fcs_cycle_engine.sv
module fcs_cycle_engine
   import fcs_pkg::*;
#(
   parameter int AW     = 18,
   parameter int DW     = 8,
   parameter int SU_CYC = 1,
   parameter int WP_CYC = 3,
   parameter int WPH_CYC = 2,
   parameter int RD_CYC = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  fcs_kind_e       kind,
   input  logic [AW-1:0]   addr_in,
   input  logic [DW-1:0]   data_in,
   output logic            act,
   output logic            oe_n,
   output logic            we_n,
   output logic            dq_oe,
   output logic [AW-1:0]   addr_out,
   output logic [DW-1:0]   data_out,
   output logic            rd_fire,
   output logic            cyc_done
);

   localparam int MAXC = fcs_max(fcs_max(SU_CYC, WP_CYC), fcs_max(WPH_CYC, RD_CYC));
   localparam int CW   = $clog2(MAXC + 1);

   typedef enum logic [2:0] {
      P_IDLE, P_SU, P_WP, P_WPH, P_TURN, P_RD
   } phase_e;

   phase_e          ph;
   logic [CW-1:0]   cnt;
   logic [AW-1:0]   addr_q;
   logic [DW-1:0]   data_q;
   logic            cnt_zero;

   generate
      if (SU_CYC < 1 || WP_CYC < 1 || WPH_CYC < 1 || RD_CYC < 1) begin : g_len_chk
         $error("fcs_cycle_engine: every phase needs at least one clock");
      end
   endgenerate

   assign cnt_zero = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= P_IDLE;
         cnt    <= '0;
         addr_q <= '0;
         data_q <= '0;
      end else if (start) begin
         addr_q <= addr_in;
         data_q <= data_in;
         if (kind == K_WR) begin
            ph  <= P_SU;
            cnt <= CW'(SU_CYC - 1);
         end else begin
            ph  <= P_TURN;
            cnt <= '0;
         end
      end else begin
         case (ph)
            P_SU: begin
               if (cnt_zero) begin
                  ph  <= P_WP;
                  cnt <= CW'(WP_CYC - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            P_WP: begin
               if (cnt_zero) begin
                  ph  <= P_WPH;
                  cnt <= CW'(WPH_CYC - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            P_TURN: begin
               ph  <= P_RD;
               cnt <= CW'(RD_CYC - 1);
            end
            P_WPH, P_RD: begin
               if (cnt_zero) ph <= P_IDLE;
               else          cnt <= cnt - 1'b1;
            end
            default: ph <= P_IDLE;
         endcase
      end
   end

   assign act      = (ph != P_IDLE);
   assign we_n     = (ph != P_WP);
   assign oe_n     = (ph != P_RD);
   assign dq_oe    = (ph == P_SU) || (ph == P_WP) || (ph == P_WPH);
   assign addr_out = addr_q;
   assign data_out = data_q;
   assign rd_fire  = (ph == P_RD) && cnt_zero;
   assign cyc_done = ((ph == P_WPH) || (ph == P_RD)) && cnt_zero;

   // R7: address and data hold still across every clock of a bus cycle
   a_r7_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != P_IDLE) && ($past(ph) != P_IDLE) |-> $stable(addr_q) && $stable(data_q));

   // R6: the low pulse on write enable is followed by the high recovery phase
   a_r6_wp_to_wph: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == P_WP) && cnt_zero |=> (ph == P_WPH));

endmodule

// File: rtl/fcs_wait_timer.sv
module fcs_wait_timer #(
   parameter int TW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [TW-1:0]   limit,
   output logic            active,
   output logic            expire
);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (load) begin
         active <= 1'b1;
         cnt    <= limit;
      end else if (active) begin
         if (cnt == '0) active <= 1'b0;
         else           cnt    <= cnt - 1'b1;
      end
   end

   assign expire = active && (cnt == '0);

   // R9: the wait counts down by exactly one per clock
   a_r9_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      active && (cnt != '0) && !load |=> active && (cnt == $past(cnt) - TW'(1)));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import fcs_pkg::*;
#(
   parameter int AW          = 18,
   parameter int DW          = 8,
   parameter int CLK_NS      = 20,
   parameter int TWP_NS      = 45,
   parameter int TWPH_NS     = 30,
   parameter int TDS_NS      = 30,
   parameter int TWC_NS      = 90,
   parameter int TACC_NS     = 90,
   parameter int PROG_WAIT   = 1500,
   parameter int SERASE_WAIT = 500000,
   parameter int CERASE_WAIT = 150000000,
   parameter bit CE_HELD     = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [1:0]      req_op,
   input  logic [AW-1:0]   req_addr,
   input  logic [DW-1:0]   req_data,
   output logic            busy,
   output logic            done,
   output logic [DW-1:0]   id_mfr,
   output logic [DW-1:0]   id_dev,
   output logic            fl_ce_n,
   output logic            fl_oe_n,
   output logic            fl_we_n,
   output logic [AW-1:0]   fl_addr,
   output logic [DW-1:0]   fl_dq_out,
   output logic            fl_dq_oe,
   input  logic [DW-1:0]   fl_dq_in
);

   localparam int WP_CYC  = fcs_cdiv(TWP_NS, CLK_NS);
   localparam int WPH_CYC = fcs_cdiv(TWPH_NS, CLK_NS);
   localparam int DS_CYC  = fcs_cdiv(TDS_NS, CLK_NS);
   localparam int WC_CYC  = fcs_cdiv(TWC_NS, CLK_NS);
   localparam int RD_CYC  = fcs_cdiv(TACC_NS, CLK_NS);
   localparam int SU_CYC  = fcs_max(1, fcs_max(DS_CYC - WP_CYC, WC_CYC - WP_CYC - WPH_CYC));
   localparam int MAXW    = fcs_max(CERASE_WAIT, fcs_max(PROG_WAIT, SERASE_WAIT));
   localparam int TW      = $clog2(MAXW + 1);

   generate
      if (CLK_NS < 1) begin : g_clk_chk
         $error("flash_cmd_seq: clock period must be positive");
      end
      if (PROG_WAIT < 0 || SERASE_WAIT < 0 || CERASE_WAIT < 0) begin : g_wait_chk
         $error("flash_cmd_seq: waits cannot be negative");
      end
      if ((SU_CYC + WP_CYC) * CLK_NS < TDS_NS) begin : g_ds_chk
         $error("flash_cmd_seq: data setup not covered");
      end
   endgenerate

   typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_RUN, S_WAIT} state_e;

   state_e          state;
   fcs_op_e         op_q;
   logic [AW-1:0]   addr_q;
   logic [DW-1:0]   data_q;
   logic [2:0]      step_q;
   logic            done_q;

   fcs_kind_e       st_kind;
   logic [AW-1:0]   st_addr;
   logic [DW-1:0]   st_data;
   logic            st_last;

   logic            eng_act;
   logic            eng_start;
   logic            rd_fire;
   logic            cyc_done;
   logic            tmr_load;
   logic            tmr_active;
   logic            tmr_expire;
   logic [TW-1:0]   tmr_limit;

   fcs_cmd_table #(.AW(AW), .DW(DW)) u_table (
      .op    (op_q),
      .step  (step_q),
      .uaddr (addr_q),
      .udata (data_q),
      .kind  (st_kind),
      .addr  (st_addr),
      .data  (st_data),
      .last  (st_last)
   );

   assign eng_start = (state == S_ISSUE);

   fcs_cycle_engine #(
      .AW(AW), .DW(DW), .SU_CYC(SU_CYC), .WP_CYC(WP_CYC),
      .WPH_CYC(WPH_CYC), .RD_CYC(RD_CYC)
   ) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (eng_start),
      .kind     (st_kind),
      .addr_in  (st_addr),
      .data_in  (st_data),
      .act      (eng_act),
      .oe_n     (fl_oe_n),
      .we_n     (fl_we_n),
      .dq_oe    (fl_dq_oe),
      .addr_out (fl_addr),
      .data_out (fl_dq_out),
      .rd_fire  (rd_fire),
      .cyc_done (cyc_done)
   );

   always_comb begin
      case (op_q)
         OP_PROG: tmr_limit = TW'(PROG_WAIT);
         OP_SECT: tmr_limit = TW'(SERASE_WAIT);
         OP_CHIP: tmr_limit = TW'(CERASE_WAIT);
         default: tmr_limit = '0;
      endcase
   end

   assign tmr_load = (state == S_RUN) && cyc_done && st_last;

   fcs_wait_timer #(.TW(TW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (tmr_load),
      .limit  (tmr_limit),
      .active (tmr_active),
      .expire (tmr_expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         op_q   <= OP_PROG;
         addr_q <= '0;
         data_q <= '0;
         step_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            S_IDLE: begin
               if (req_valid && !done_q) begin
                  op_q   <= fcs_op_e'(req_op);
                  addr_q <= req_addr;
                  data_q <= req_data;
                  step_q <= '0;
                  state  <= S_ISSUE;
               end
            end
            S_ISSUE: state <= S_RUN;
            S_RUN: begin
               if (cyc_done) begin
                  if (st_last) begin
                     state <= S_WAIT;
                  end else begin
                     step_q <= step_q + 1'b1;
                     state  <= S_ISSUE;
                  end
               end
            end
            default: begin
               if (tmr_expire) begin
                  done_q <= 1'b1;
                  state  <= S_IDLE;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_mfr <= '0;
         id_dev <= '0;
      end else if (rd_fire) begin
         if (step_q == 3'd3) id_mfr <= fl_dq_in;
         else                id_dev <= fl_dq_in;
      end
   end

   generate
      if (CE_HELD) begin : g_ce_burst
         assign fl_ce_n = !((state == S_ISSUE) || (state == S_RUN));
      end else begin : g_ce_cycle
         assign fl_ce_n = !eng_act;
      end
   endgenerate

   assign busy = (state != S_IDLE);
   assign done = done_q;

   // R8: the data drivers are off whenever the flash may drive the bus
   a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_oe_n |-> !fl_dq_oe);

   // R6: a write strobe only occurs with the chip selected and reads off
   a_r6_we_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_we_n |-> !fl_ce_n && fl_oe_n);

   // R9: done is a single-clock pulse raised when the block is no longer busy
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R10: a running operation keeps its latched request
   a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (state != S_IDLE) |=> $stable(op_q) && $stable(addr_q));

   // R9: the wait timer only runs once the command chain has finished
   a_r9_wait_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_active |-> !eng_act);

endmodule

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;

   localparam int PW   = 20;
   localparam int SEW  = 35;
   localparam int CEW  = 50;
   localparam int SU   = 1;
   localparam int WP   = 3;
   localparam int WPH  = 2;
   localparam int RD   = 5;
   localparam logic [7:0] MFR = 8'h3C;
   localparam logic [7:0] DEV = 8'hA7;

   typedef struct {
      logic        ce_n, oe_n, we_n, dq_oe, busy, done;
      logic [17:0] addr;
      logic [7:0]  data;
      int          rq_bus;
      int          rq_val;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'd0;
   logic [17:0] req_addr = '0;
   logic [7:0]  req_data = '0;
   logic        busy, done;
   logic [7:0]  id_mfr, id_dev;
   logic        fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
   logic [17:0] fl_addr;
   logic [7:0]  fl_dq_out;
   logic [7:0]  fl_dq_in;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   exp_t exp_q[$];

   always #10 clk = ~clk;

   assign fl_dq_in = fl_oe_n ? 8'h00 : (fl_addr[0] ? DEV : MFR);

   flash_cmd_seq #(
      .PROG_WAIT(PW), .SERASE_WAIT(SEW), .CERASE_WAIT(CEW)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
      .id_mfr(id_mfr), .id_dev(id_dev), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
      .fl_we_n(fl_we_n), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
      .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
   );

   task automatic chk(input string what, input int rq, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL R%0d %s: actual=%0h expected=%0h at %0t", rq, what, act, expv, $time);
      end
   endtask

   function automatic exp_t idle_e(input logic b, input int rq);
      exp_t e;
      e.ce_n = 1; e.oe_n = 1; e.we_n = 1; e.dq_oe = 0;
      e.busy = b; e.done = 0; e.addr = '0; e.data = '0;
      e.rq_bus = rq; e.rq_val = rq;
      return e;
   endfunction

   // R7: one gap clock before each bus cycle
   task automatic push_gap();
      exp_q.push_back(idle_e(1'b1, 7));
   endtask

   // R6: write cycle shape SU/WP/WPH
   task automatic push_wr(input logic [17:0] a, input logic [7:0] d, input int rq);
      exp_t e;
      push_gap();
      for (int i = 0; i < SU + WP + WPH; i++) begin
         e.ce_n = 0; e.oe_n = 1; e.dq_oe = 1; e.busy = 1; e.done = 0;
         e.we_n = !(i >= SU && i < SU + WP);
         e.addr = a; e.data = d; e.rq_bus = 6; e.rq_val = rq;
         exp_q.push_back(e);
      end
   endtask

   // R8: read cycle, turnaround then RD clocks with OE low
   task automatic push_rd(input logic [17:0] a);
      exp_t e;
      push_gap();
      for (int i = 0; i < 1 + RD; i++) begin
         e.ce_n = 0; e.oe_n = (i == 0); e.we_n = 1; e.dq_oe = 0;
         e.busy = 1; e.done = 0; e.addr = a; e.data = '0;
         e.rq_bus = 8; e.rq_val = 5;
         exp_q.push_back(e);
      end
   endtask

   // R9: L+1 busy wait clocks then one done clock
   task automatic push_wait(input int l);
      exp_t e;
      for (int i = 0; i < l + 1; i++) exp_q.push_back(idle_e(1'b1, 9));
      e = idle_e(1'b0, 9);
      e.done = 1;
      exp_q.push_back(e);
   endtask

   task automatic push_erase_head(input int rq);
      push_wr(18'h05555, 8'hAA, rq);
      push_wr(18'h02AAA, 8'h55, rq);
      push_wr(18'h05555, 8'h80, rq);
      push_wr(18'h05555, 8'hAA, rq);
      push_wr(18'h02AAA, 8'h55, rq);
   endtask

   task automatic issue(input logic [1:0] op, input logic [17:0] a, input logic [7:0] d);
      @(negedge clk);
      req_valid = 1; req_op = op; req_addr = a; req_data = d;
      case (op)
         2'd0: begin // R2
            push_wr(18'h05555, 8'hAA, 2);
            push_wr(18'h02AAA, 8'h55, 2);
            push_wr(18'h05555, 8'hA0, 2);
            push_wr(a, d, 2);
            push_wait(PW);
         end
         2'd1: begin // R3
            push_erase_head(3);
            push_wr(a, 8'h30, 3);
            push_wait(SEW);
         end
         2'd2: begin // R4
            push_erase_head(4);
            push_wr(18'h05555, 8'h10, 4);
            push_wait(CEW);
         end
         default: begin // R5
            push_wr(18'h05555, 8'hAA, 5);
            push_wr(18'h02AAA, 8'h55, 5);
            push_wr(18'h05555, 8'h90, 5);
            push_rd(18'h00000);
            push_rd(18'h00001);
            push_wr(18'h00000, 8'hF0, 5);
            push_wait(0);
         end
      endcase
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // per-clock comparison against the reference trace
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (!finished) begin
            exp_t e;
            if (exp_q.size() != 0) e = exp_q.pop_front();
            else e = idle_e(1'b0, 1);
            chk("busy", (e.rq_bus == 9 || e.rq_val == 1) ? e.rq_val : 10, busy, e.busy);
            chk("done", e.rq_val == 1 ? 1 : 9, done, e.done);
            chk("ce_n", e.rq_bus, fl_ce_n, e.ce_n);
            chk("oe_n", e.rq_bus, fl_oe_n, e.oe_n);
            chk("we_n", e.rq_bus, fl_we_n, e.we_n);
            chk("dq_oe", e.rq_bus == 6 ? 8 : e.rq_bus, fl_dq_oe, e.dq_oe);
            if (!e.ce_n) chk("addr", e.rq_val, fl_addr, e.addr);
            if (e.dq_oe) chk("data", e.rq_val, fl_dq_out, e.data);
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: idle state checked by the comparator during and after reset
      rst_n = 1;
      repeat (3) @(negedge clk);
      issue(2'd0, 18'h2F0A1, 8'h5C);
      // R10: a request during the operation is ignored
      repeat (7) @(negedge clk);
      req_valid = 1; req_op = 2'd2; req_addr = 18'h11111; req_data = 8'h00;
      @(negedge clk);
      req_valid = 0;
      drain();
      issue(2'd1, 18'h3FE00, 8'h00);
      drain();
      issue(2'd2, 18'h00000, 8'h00);
      drain();
      issue(2'd3, 18'h00000, 8'h00);
      drain();
      chk("id_mfr", 5, id_mfr, MFR);
      chk("id_dev", 5, id_dev, DEV);
      issue(2'd0, 18'h3FFFF, 8'hFF);
      drain();
      issue(2'd0, 18'h00000, 8'h00);
      drain();
      // R5: identify results remain after later operations
      chk("id_mfr_kept", 5, id_mfr, MFR);
      finish_run();
   end

endmodule